// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block holds the interrupt-pending state for one processor core. Software, or another core, raises pending bits by writing a word with ones in the bit positions to set. The owning core acknowledges by writing ones to a separate clear port. A 32-bit enable register selects which pending bits may assert the core's interrupt line. Eight 32-bit mailbox words carry message payloads alongside the interrupt.

Pending status never changes through a direct write. It moves only through the set port, the clear port, or a one-cycle post pulse from a send engine. The interrupt line is a register that changes only on those events. A set raises it when the new status has an enabled bit. A clear lowers it only when the whole status has become zero and the enable register is nonzero. Writing the enable register alone never moves the line. The register port is a single-cycle 32-bit read/write interface with an 8-bit byte offset, and read data is registered.

Top module: `ipi_core_regs`

## Requirements
- R1: Offsets decode on address bits [7:2], and bits [1:0] are ignored. Status is at 0x00, enable at 0x04, set at 0x08 and clear at 0x0C. Mailbox word i is at 0x20 + 4*i. For a read issued with rd_en in one cycle, rdata shows the value in the next cycle and holds it until the next read.
- R2: A write to the status offset leaves status unchanged.
- R3: A set write ORs wdata into status. In the next cycle irq is 1 if (new status AND enable) is nonzero; otherwise irq keeps its value.
- R4: A clear write clears every status bit that is 1 in wdata. In the next cycle irq is 0 only if the new status is zero and enable is nonzero; otherwise irq keeps its value.
- R5: The enable register reads back what was written, and writing it does not change irq.
- R6: Reads of the set and clear offsets return zero.
- R7: The eight mailbox words are each independently writable and readable.
- R8: Writes to undefined offsets (0x10–0x1F, and 0x40 and above) change no register, and reads of them return zero.
- R9: After reset, status, enable, every mailbox word, rdata and irq are zero.
- R10: A cycle with post_en high ORs post_bits into status and applies the same raise rule as a set write.
- R11: When a clear write and a post occur in the same cycle, the new status is (status AND NOT clear bits) OR post bits. The raise rule is checked first, and the lower rule applies only if the raise rule does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| post_en | input | 1 | Post pulse from a send engine |
| post_bits | input | 32 | Bits to OR into status on a post |
| irq | output | 1 | Core interrupt line |

## Verification
The bench builds the block with its default parameters: 32-bit data, 8-bit offsets and eight mailbox words starting at word 8. With these values every mailbox slot and both undefined gaps (the words between clear and the mailbox, and the words past it) can be reached within a short run. The bench walks the interrupt line through its asymmetric cases: a set while every bit is masked, a partial clear that must leave the line high, and a full clear with enable zero that must also leave it high. It also checks a post that lands in the same cycle as a clear.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_EN,
    SEL_SET,
    SEL_CLR,
    SEL_MBOX
  } reg_sel_e;

  localparam int unsigned STAT_WORD = 0;
  localparam int unsigned EN_WORD   = 1;
  localparam int unsigned SET_WORD  = 2;
  localparam int unsigned CLR_WORD  = 3;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int MBOX_WORDS = 8,
  parameter int MBOX_BASE  = 8,
  localparam int IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1,
  localparam int WORD_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  mbox_idx
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] rel;

  assign word = addr[ADDR_W-1:2];
  assign rel  = word - WORD_W'(MBOX_BASE);
  assign mbox_idx = rel[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (word == WORD_W'(STAT_WORD))      sel = SEL_STAT;
    else if (word == WORD_W'(EN_WORD))   sel = SEL_EN;
    else if (word == WORD_W'(SET_WORD))  sel = SEL_SET;
    else if (word == WORD_W'(CLR_WORD))  sel = SEL_CLR;
    else if (32'(word) >= MBOX_BASE && 32'(word) < MBOX_BASE + MBOX_WORDS)
      sel = SEL_MBOX;
  end
endmodule

// File: rtl/ipi_status_ctl.sv
module ipi_status_ctl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_wr,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              post_en,
  input  logic [DATA_W-1:0] post_bits,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] enable,
  output logic              irq
);
  logic [DATA_W-1:0] set_bits, clr_bits, status_nx;
  logic              set_any;

  assign set_any   = set_wr | post_en;
  assign set_bits  = (set_wr ? wdata : '0) | (post_en ? post_bits : '0);
  assign clr_bits  = clr_wr ? wdata : '0;
  assign status_nx = (status & ~clr_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      if (en_wr) enable <= wdata;
      // raise takes precedence; lower needs empty status and nonzero enable
      if (set_any && |(status_nx & enable)) irq <= 1'b1;
      else if (clr_wr && status_nx == '0 && enable != '0) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [MBOX_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MBOX_WORDS; i++) mem[i] <= '0;
    end else if (wr) begin
      mem[idx] <= wdata;
    end
  end

  assign rd_word = mem[idx];
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int MBOX_WORDS = 8,
  parameter int MBOX_BASE  = 8,
  localparam int IDX_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              post_en,
  input  logic [DATA_W-1:0] post_bits,
  output logic              irq
);
  reg_sel_e          sel;
  logic [IDX_W-1:0]  mbox_idx;
  logic [DATA_W-1:0] status_q, enable_q, mbox_rd, rd_mux;

  ipi_addr_decode #(
    .ADDR_W(ADDR_W), .MBOX_WORDS(MBOX_WORDS), .MBOX_BASE(MBOX_BASE)
  ) u_dec (
    .addr(addr), .sel(sel), .mbox_idx(mbox_idx)
  );

  ipi_status_ctl #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst),
    .en_wr(wr_en && sel == SEL_EN),
    .set_wr(wr_en && sel == SEL_SET),
    .clr_wr(wr_en && sel == SEL_CLR),
    .wdata(wdata), .post_en(post_en), .post_bits(post_bits),
    .status(status_q), .enable(enable_q), .irq(irq)
  );

  ipi_mailbox #(.DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_mbox (
    .clk(clk), .rst(rst),
    .wr(wr_en && sel == SEL_MBOX),
    .idx(mbox_idx), .wdata(wdata), .rd_word(mbox_rd)
  );

  always_comb begin
    case (sel)
      SEL_STAT: rd_mux = status_q;
      SEL_EN:   rd_mux = enable_q;
      SEL_MBOX: rd_mux = mbox_rd;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/ipi_core_regs_chk.sv
module ipi_core_regs_chk
  import ipi_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int MBOX_WORDS = 8,
  parameter int MBOX_BASE  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              post_en,
  input logic              irq,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] enable
);
  logic [ADDR_W-3:0] w;
  logic is_set, is_clr, is_stat, is_undef;
  assign w        = addr[ADDR_W-1:2];
  assign is_set   = (32'(w) == SET_WORD);
  assign is_clr   = (32'(w) == CLR_WORD);
  assign is_stat  = (32'(w) == STAT_WORD);
  assign is_undef = (32'(w) > CLR_WORD && 32'(w) < MBOX_BASE) ||
                    (32'(w) >= MBOX_BASE + MBOX_WORDS);

  a_r2_status_ro: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_stat && !post_en) |=> $stable(status));

  a_r3_set_raises: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_set) |=> (((status & enable) == '0) || irq));

  a_r4_clear_lowers: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_clr && !post_en) |=> ((status != '0) || (enable == '0) || !irq));

  a_r5_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && (is_set || is_clr)) && !post_en) |=> $stable(irq));

  a_r6_setclr_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (is_set || is_clr)) |=> (rdata == '0));

  a_r8_undef_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_undef) |=> (rdata == '0));
endmodule

bind ipi_core_regs ipi_core_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MBOX_WORDS(MBOX_WORDS), .MBOX_BASE(MBOX_BASE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .post_en(post_en), .irq(irq),
  .status(status_q), .enable(enable_q)
);

// File: tb/sim_ipi_core_regs.sv
module sim_ipi_core_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, wr_en = 0, rd_en = 0, post_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, post_bits = 0, rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  ipi_core_regs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .post_en(post_en), .post_bits(post_bits),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pop expected read data once the registered result is visible
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic post(input logic [31:0] b);
    @(negedge clk); post_en = 1; post_bits = b;
    @(negedge clk); post_en = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk_irq(0, "R9 reset");
    rd(8'h00, 0, "R9 status reset");
    rd(8'h04, 0, "R9 enable reset");
    rd(8'h3C, 0, "R9 mailbox reset");
    // R3: masked set does not raise
    wr(8'h08, 32'h5);
    chk_irq(0, "R3 masked set");
    rd(8'h00, 32'h5, "R3 status after set");
    // R5: enable write alone leaves irq
    wr(8'h04, 32'h1);
    chk_irq(0, "R5 enable write");
    rd(8'h04, 32'h1, "R5 enable readback");
    wr(8'h08, 32'h2);
    chk_irq(1, "R3 enabled set raises");
    // R2: status write ignored
    wr(8'h00, 32'hFFFF);
    rd(8'h00, 32'h7, "R2 status read-only");
    // R4: partial clear keeps irq
    wr(8'h0C, 32'h1);
    chk_irq(1, "R4 partial clear");
    rd(8'h00, 32'h6, "R4 status after clear");
    // R4: full clear with enable zero keeps irq
    wr(8'h04, 32'h0);
    chk_irq(1, "R5 enable zero write");
    wr(8'h0C, 32'h6);
    chk_irq(1, "R4 clear with enable zero");
    wr(8'h04, 32'h10);
    wr(8'h0C, 32'h0);
    chk_irq(0, "R4 clear lowers");
    // R6
    rd(8'h08, 0, "R6 set reads zero");
    rd(8'h0C, 0, "R6 clear reads zero");
    // R7 mailbox
    for (int i = 0; i < 8; i++) wr(8'(8'h20 + 4*i), 32'hA500_0000 + 32'(i*17));
    for (int i = 0; i < 8; i++) rd(8'(8'h20 + 4*i), 32'hA500_0000 + 32'(i*17), "R7 mailbox");
    rd(8'h21, 32'hA500_0000, "R1 low bits ignored");
    // R8 undefined offsets
    wr(8'h40, 32'hDEAD);
    wr(8'h10, 32'hBEEF);
    wr(8'h80, 32'h1234);
    rd(8'h40, 0, "R8 undefined read 0x40");
    rd(8'h14, 0, "R8 undefined read 0x14");
    rd(8'h20, 32'hA500_0000, "R8 mailbox untouched");
    rd(8'h04, 32'h10, "R8 enable untouched");
    chk_irq(0, "R8 irq untouched");
    // R10 post
    wr(8'h04, 32'h300);
    post(32'h100);
    chk_irq(1, "R10 post raises");
    rd(8'h00, 32'h100, "R10 status after post");
    // R11 clear and post together
    @(negedge clk); wr_en = 1; addr = 8'h0C; wdata = 32'h100; post_en = 1; post_bits = 32'h200;
    @(negedge clk); wr_en = 0; post_en = 0;
    chk_irq(1, "R11 clear with post");
    rd(8'h00, 32'h200, "R11 status merge");
    wr(8'h0C, 32'h200);
    chk_irq(0, "R11 final clear lowers");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule